// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between on-chip logic running on a single system clock and an external asynchronous static RAM of 512K words by 8 bits. A requester presents one access at a time on a valid/ready interface: a read/write flag, a 19-bit word address and, for writes, a data byte. The controller turns that access into a sequence of levels on the memory's pins. Every phase of the sequence lasts a whole number of clock cycles, and each number is derived from minimum memory timings given in nanoseconds. Read data returns on a one-cycle valid pulse.

The memory pins are active-low chip select, output enable and write strobe, plus the address bus. The shared 8-bit data bus is split into an output value, an output-drive enable and an input value, and the pad ring joins them into one tristate bus. Between accesses the memory is deselected, which holds it in standby. A write is framed by chip select and write strobe falling and rising on the same clock edges. The output enable stays high for the whole write, so the memory never drives the bus while the controller does. After a read, the controller waits out the memory's output-release window before it may drive the bus again.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, chip select, output enable and write strobe are all high (inactive), the data-drive enable is low and `req_ready` is high.
- R2: A write takes chip select and write strobe low on the same clock edge, holds both low for WR_CYC consecutive cycles (14 with the default parameters) and raises both on the same edge. Output enable stays high throughout.
- R3: During a write, address and data out are stable for every cycle in which the write strobe is low. The data-drive enable and the data stay asserted for one further cycle after the edge that ends the write.
- R4: A read holds chip select and output enable low, with the write strobe high and the data-drive enable low, for exactly RD_CYC consecutive cycles (14 by default).
- R5: The byte on the data bus in the last cycle of the read window is returned on `rsp_rdata`. `rsp_valid` is high for exactly one cycle, the cycle that begins RD_CYC clock edges after the edge that accepted the read.
- R6: After output enable rises at the end of a read, the data-drive enable stays low for at least HZ_CYC+1 cycles (5+1 by default).
- R7: The data-drive enable is high only while output enable is high, and it is low in the cycle before any falling edge of output enable.
- R8: A request is accepted only on a clock edge where `req_ready` is high. `req_ready` goes low in the cycle after acceptance and stays low until the access and its turnaround are complete.
- R9: Every phase length is the nanosecond minimum divided by the clock period, rounded up, with a floor of one cycle. The write window is the largest of the strobe-width, address-to-end, select-to-end, data-setup and write-cycle values. The read window is the largest of the read-cycle, address-access and output-enable-access values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| sram_addr | output | 19 | Memory address pins |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_o | output | 8 | Data value driven onto the bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | 8 | Data value read from the bus |

## Verification
Pin levels change on the acceptance edge, so a write's strobe is low in the cycle that follows the accepting edge and for the next WR_CYC-1 cycles. A read's response is due in the cycle that begins RD_CYC edges after acceptance. The bench stamps each accepted read with its edge count, queues the expected byte with that due cycle, and the monitor compares both data and arrival cycle when `rsp_valid` is seen. The memory model puts valid data on the bus only after RD_CYC cycles of read mode. It counts strobe-low cycles and cycles since output enable rose, sampling pins on the falling clock edge, so every count reflects whole cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_WHOLD = 3'd2,
    ST_READ  = 3'd3,
    ST_TURN  = 3'd4
  } seq_state_t;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap_en;
      if (cap_en) rdata <= bus_in;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R5

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 4,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_DOE_NS  = 30,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_PWE_NS  = 40,
  parameter int unsigned T_AW_NS   = 50,
  parameter int unsigned T_SCE_NS  = 50,
  parameter int unsigned T_SD_NS   = 25,
  parameter int unsigned T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned WR_CYC = max3(
    max3(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS),
         ns_to_cyc(T_SCE_NS, CLK_NS)),
    ns_to_cyc(T_SD_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int unsigned RD_CYC = max3(ns_to_cyc(T_RC_NS, CLK_NS),
    ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned T_MAX  = max3(WR_CYC, RD_CYC, HZ_CYC);
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

  seq_state_t        state_q, state_d;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // Named events for the assertions below.
  logic accept, wr_end, rd_end, cap_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_end    = (state_q == ST_WRITE) && tmr_exp;
  assign rd_end    = (state_q == ST_READ)  && tmr_exp;
  assign cap_en    = rd_end;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WRITE;
          tmr_val = CNT_W'(WR_CYC - 1);
        end else begin
          state_d = ST_READ;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_WRITE: if (wr_end) state_d = ST_WHOLD;
      ST_WHOLD: state_d = ST_IDLE;
      ST_READ: if (rd_end) begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HZ_CYC - 1);
      end
      ST_TURN: if (tmr_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Pin levels are registered from the next state: glitch-free pads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_ce_n  <= !(state_d == ST_WRITE || state_d == ST_READ);
      sram_we_n  <= (state_d != ST_WRITE);
      sram_oe_n  <= (state_d != ST_READ);
      sram_dq_oe <= (state_d == ST_WRITE || state_d == ST_WHOLD);
    end
  end

  assign sram_addr = addr_q;
  assign sram_dq_o = wdata_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .bus_in (sram_dq_i),
    .rdata  (rsp_rdata),
    .rvalid (rsp_valid)
  );

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n); // R2
  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R2
  AST_WR_RELEASE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> (sram_ce_n && sram_we_n)); // R2
  AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_dq_o) && $stable(sram_addr))); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe); // R3
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R7
  AST_RELEASE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> !$past(sram_dq_oe)); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R8
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe)); // R1

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

  localparam int CLK_NS = 4;
  // Cycle budgets restated from the requirements (ceil of ns / period).
  localparam int WR_EXP = (55 + CLK_NS - 1) / CLK_NS; // largest of 40,50,50,25,55 ns
  localparam int RD_EXP = (55 + CLK_NS - 1) / CLK_NS; // largest of 55,55,30 ns
  localparam int HZ_EXP = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = 8'hEE;

  always #2 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory model -----------------
  byte unsigned mem_m[int];
  int  wcnt = 0, rcnt = 0, gap = 0;
  bit  had_read = 0, prev_dq_oe = 0, prev_oe_n = 1, wr_bad = 0;
  logic [7:0]  last_dq;
  logic [18:0] last_a;

  always @(negedge clk) if (rst_n) begin
    // write side
    if (!sram_ce_n && !sram_we_n) begin
      if (wcnt > 0 && (sram_dq_o != last_dq || sram_addr != last_a)) wr_bad = 1;
      if (!sram_oe_n || !sram_dq_oe) wr_bad = 1;
      wcnt++;
      last_dq = sram_dq_o;
      last_a  = sram_addr;
    end else if (wcnt > 0) begin
      check(wcnt == WR_EXP, "R2 strobe-low cycles", wcnt, WR_EXP);
      check(sram_ce_n && sram_we_n, "R2 paired release", {sram_ce_n, sram_we_n}, 2'b11);
      check(!wr_bad, "R3 stable data/addr, oe high", wr_bad, 0);
      check(sram_dq_oe && sram_dq_o == last_dq, "R3 hold after end", sram_dq_oe, 1);
      mem_m[int'(last_a)] = last_dq;
      wcnt = 0; wr_bad = 0;
    end
    // read side
    if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
      if (prev_oe_n) check(!prev_dq_oe, "R7 drive off before oe falls", prev_dq_oe, 0);
      rcnt++;
      if (sram_dq_oe) check(0, "R7 drive during read", 1, 0);
    end else if (rcnt > 0) begin
      check(rcnt == RD_EXP, "R4 read window cycles", rcnt, RD_EXP);
      rcnt = 0; had_read = 1; gap = 0;
    end
    if (sram_oe_n) gap++;
    if (sram_dq_oe && !prev_dq_oe && had_read) begin
      check(gap >= HZ_EXP + 1, "R6 turnaround", gap, HZ_EXP + 1);
      had_read = 0;
    end
    prev_dq_oe = sram_dq_oe;
    prev_oe_n  = sram_oe_n;
    // bus value: valid only once the access time has elapsed
    if (rcnt >= RD_EXP)
      sram_dq_i = mem_m.exists(int'(sram_addr)) ? mem_m[int'(sram_addr)] : 8'h00;
    else
      sram_dq_i = 8'hEE;
  end

  // ---------------- scoreboard -----------------
  typedef struct { logic [7:0] d; int due; } exp_t;
  exp_t sbq[$];
  byte unsigned ref_m[int];

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (sbq.size() == 0) check(0, "R5 unexpected response", rsp_rdata, 0);
    else begin
      exp_t e;
      e = sbq.pop_front();
      check(rsp_rdata == e.d, "R5 read data", rsp_rdata, e.d);
      check(cyc == e.due, "R5 response cycle", cyc, e.due);
    end
  end

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
    int acc;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    acc = cyc;
    req_valid = 0; req_addr = ~a; req_wdata = ~d;
    check(!req_ready, "R8 busy after accept", req_ready, 0);
    if (wr) ref_m[int'(a)] = d;
    else begin
      exp_t e;
      e.d = ref_m.exists(int'(a)) ? ref_m[int'(a)] : 8'h00;
      e.due = acc + RD_EXP;
      sbq.push_back(e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [18:0] addrs[16];
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n, "R1 idle pins",
          {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
    check(!sram_dq_oe, "R1 drive off", sram_dq_oe, 0);
    check(req_ready, "R1 ready", req_ready, 1);
    check(!rsp_valid, "R1 no response", rsp_valid, 0);
    // read of an unwritten word, then read-after-write and write-after-read
    do_req(0, 19'h00010, 8'h00);
    do_req(1, 19'h00000, 8'h3C);
    do_req(0, 19'h00000, 8'h00);
    do_req(1, 19'h00000, 8'hC3);
    do_req(0, 19'h00000, 8'h00);
    do_req(1, 19'h7FFFF, 8'hFF);
    do_req(1, 19'h40000, 8'h01);
    do_req(0, 19'h7FFFF, 8'h00);
    do_req(0, 19'h40000, 8'h00);
    // random block write, then interleaved reads and overwrites
    for (int i = 0; i < 16; i++) begin
      addrs[i] = 19'($urandom);
      do_req(1, addrs[i], 8'($urandom));
    end
    for (int i = 0; i < 16; i++) begin
      do_req(0, addrs[i], 8'h00);
      if (i % 3 == 0) do_req(1, addrs[i], 8'($urandom));
      if (i % 3 == 0) do_req(0, addrs[i], 8'h00);
    end
    repeat (40) @(negedge clk);
    check(sbq.size() == 0, "R5 all responses returned", sbq.size(), 0);
    check(req_ready && sram_ce_n && !sram_dq_oe, "R1 idle at end", req_ready, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule